// File: doc/BRIEF.md
# Functional-Unit Reservation Hazard Checker

This block decides, cycle by cycle, whether each of up to three candidate instructions may start without colliding with functional-unit bookings already made for upcoming cycles. It keeps a table of unit bookings that looks nine cycles ahead. The table covers two integer pipes, one floating-point pipe, a divider, and two write-back ports. Every instruction class books units over several cycles. A request is granted only if its whole multi-cycle booking fits into the table. When it is granted, the booking is merged into the table.

Each request carries a class code. The checker returns a grant per request, plus the integer pipe and the write-back port that the request was given. Requests are looked at in slot order within a cycle, and each grant is visible to the slots after it. A separate advance strobe moves time forward by one cycle. The table then slides one row toward the present, and an empty row enters at the far end. Without the strobe, all bookings stay in place, so further requests can be tried in the same cycle.

Top module: `unit_reservation_checker`

## Requirements
- R1: After reset the table is empty. Any one request of any class is then granted.
- R2: An integer request (class 1) books pipe 0 at offset 0, or pipe 1 if pipe 0 is already booked at offset 0. It books port 0 at offset 1, or port 1 if port 0 is booked there. `pipe_sel`=1 means pipe 1 and `port_sel`=1 means port 1.
- R3: A multiply request (class 2) books pipe 1 at offset 0 and a write-back port at offset 3. The port follows the ordered choice of R2, and `pipe_sel` reads 1.
- R4: A divide request (class 3) books pipe 1 at offset 0 and the divider at offsets 1 through 8. It also books a write-back port at offset 8. A second divide is refused until eight advances have passed since the first.
- R5: A floating-point request (class 4) books the floating-point pipe at offset 0 and a write-back port at offset 2. `pipe_sel` reads 0.
- R6: A request is granted only if every unit it needs is free at every offset. A refused request changes nothing in the table. Class codes 0, 5, 6 and 7 are never granted. When `grant` is low, `pipe_sel` and `port_sel` read 0.
- R7: Slots are resolved in the order 0, 1, 2. Bookings granted to a lower slot in the same cycle are seen by the higher slots.
- R8: With `adv` high, offset k+1 becomes offset k and the farthest offset becomes empty. With `adv` low, all bookings, including that cycle's grants, stay at their offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the table |
| adv | input | 1 | Advance strobe: move the table one cycle forward at this edge |
| req_cls | input | 9 | Three 3-bit class codes; slot s uses bits [3s+2:3s] |
| grant | output | 3 | Per-slot grant, combinational from the current table and requests |
| pipe_sel | output | 3 | Per-slot integer pipe given (1 = pipe 1) |
| port_sel | output | 3 | Per-slot write-back port given (1 = port 1) |

## Verification
The bench goes after the pipe 0 to pipe 1 and port 0 to port 1 fallbacks. A design that got these wrong would either refuse a request that still fits or hand out a unit twice. The bench probes the divider gap of exactly eight advances. A design with an off-by-one in the divider window would let a second divide in one cycle early, or hold it one cycle too long. It also repeats requests without an advance. A design that shifted or dropped its bookings there would grant a second floating-point start in the same cycle. Finally, it fills the lower slots so that a higher slot must see their bookings. A design that gave each slot only the registered table would then grant three integer starts at once.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int UNITS    = 6;
    localparam int DIV_BUSY = 7;
    localparam int DEPTH    = DIV_BUSY + 2;
    localparam int CLS_W    = 3;

    // unit bit positions inside a table row
    localparam int U_I0 = 0;
    localparam int U_I1 = 1;
    localparam int U_FP = 2;
    localparam int U_DV = 3;
    localparam int U_P0 = 4;
    localparam int U_P1 = 5;

    // write-back offsets per class
    localparam int INT_WB = 1;
    localparam int FP_WB  = 2;
    localparam int MUL_WB = 3;
    localparam int DIV_WB = DEPTH - 1;

    localparam logic [CLS_W-1:0] CLS_NONE = 3'd0;
    localparam logic [CLS_W-1:0] CLS_INT  = 3'd1;
    localparam logic [CLS_W-1:0] CLS_MUL  = 3'd2;
    localparam logic [CLS_W-1:0] CLS_DIV  = 3'd3;
    localparam logic [CLS_W-1:0] CLS_FP   = 3'd4;

    typedef logic [UNITS-1:0] row_t;
    typedef row_t [DEPTH-1:0] tbl_t;

    typedef struct packed {
        tbl_t tbl;
    } tbl_state_t;
endpackage

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
(
    input  tbl_t             tbl_in,
    input  logic [CLS_W-1:0] cls,
    output logic             grant,
    output logic             pipe_sel,
    output logic             port_sel,
    output tbl_t             tbl_out
);
    tbl_t need;
    logic valid;
    logic fits;
    logic pipe_pick;
    logic port_pick;
    int   wb_row;

    always_comb begin
        need      = '0;
        valid     = 1'b1;
        pipe_pick = 1'b0;
        wb_row    = INT_WB;
        case (cls)
            CLS_INT: begin
                pipe_pick = tbl_in[0][U_I0];
                need[0][pipe_pick ? U_I1 : U_I0] = 1'b1;
                wb_row = INT_WB;
            end
            CLS_MUL: begin
                pipe_pick = 1'b1;
                need[0][U_I1] = 1'b1;
                wb_row = MUL_WB;
            end
            CLS_DIV: begin
                pipe_pick = 1'b1;
                need[0][U_I1] = 1'b1;
                for (int r = 1; r < DEPTH; r++) begin
                    need[r][U_DV] = 1'b1;
                end
                wb_row = DIV_WB;
            end
            CLS_FP: begin
                need[0][U_FP] = 1'b1;
                wb_row = FP_WB;
            end
            default: valid = 1'b0;
        endcase
        // ordered port choice: port 0 unless already booked on that row
        port_pick = tbl_in[wb_row][U_P0];
        if (valid) begin
            need[wb_row][port_pick ? U_P1 : U_P0] = 1'b1;
        end
        fits     = ((tbl_in & need) == '0);
        grant    = valid && fits;
        pipe_sel = grant && pipe_pick;
        port_sel = grant && port_pick;
        tbl_out  = grant ? (tbl_in | need) : tbl_in;
    end
endmodule

// File: rtl/rsv_table.sv
module rsv_table
    import rsv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  tbl_t tbl_in,
    output tbl_t tbl_q
);
    tbl_state_t st_d;
    tbl_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            for (int r = 0; r < DEPTH - 1; r++) begin
                st_d.tbl[r] = tbl_in[r+1];
            end
            st_d.tbl[DEPTH-1] = '0;
        end else begin
            st_d.tbl = tbl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_q = st_q.tbl;

    p_far_row_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tbl_q[DEPTH-1] == '0));

    p_hold_no_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> (tbl_q == $past(tbl_in)));

    p_slide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tbl_q[0] == $past(tbl_in[1])));
endmodule

// File: rtl/unit_reservation_checker.sv
module unit_reservation_checker
    import rsv_pkg::*;
#(
    parameter int NUM_SLOTS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic [NUM_SLOTS*CLS_W-1:0] req_cls,
    output logic [NUM_SLOTS-1:0]       grant,
    output logic [NUM_SLOTS-1:0]       pipe_sel,
    output logic [NUM_SLOTS-1:0]       port_sel
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    tbl_t tbl_q;
    tbl_t chain [NUM_SLOTS+1];

    assign chain[0] = tbl_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        rsv_slot u_slot (
            .tbl_in   (chain[s]),
            .cls      (req_cls[s*CLS_W +: CLS_W]),
            .grant    (grant[s]),
            .pipe_sel (pipe_sel[s]),
            .port_sel (port_sel[s]),
            .tbl_out  (chain[s+1])
        );

        // fallback to pipe 1 only when pipe 0 was already booked now
        p_pipe_fallback_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[s] && req_cls[s*CLS_W +: CLS_W] == CLS_INT && pipe_sel[s])
            |-> chain[s][0][U_I0]);

        p_quiet_when_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !grant[s] |-> (!pipe_sel[s] && !port_sel[s]));
    end

    rsv_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .tbl_in (chain[NUM_SLOTS]),
        .tbl_q  (tbl_q)
    );

    logic [CNT_W-1:0] n_int;
    logic [CNT_W-1:0] n_fp;
    logic             div_any;

    always_comb begin
        n_int   = '0;
        n_fp    = '0;
        div_any = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (grant[s]) begin
                case (req_cls[s*CLS_W +: CLS_W])
                    CLS_INT, CLS_MUL: n_int = n_int + 1'b1;
                    CLS_DIV: begin
                        n_int   = n_int + 1'b1;
                        div_any = 1'b1;
                    end
                    CLS_FP:  n_fp = n_fp + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    p_issue_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (n_int <= CNT_W'(2)) && (n_fp <= CNT_W'(1)));

    p_div_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_any |=> !div_any);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && grant == '0) |=> (tbl_q == $past(tbl_q)));
endmodule

// File: tb/unit_reservation_checker_bench.sv
module unit_reservation_checker_bench;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic [NS*3-1:0] req_cls = '0;
    logic [NS-1:0] grant, pipe_sel, port_sel;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [8:0][5:0] mt;

    always #5 clk = ~clk;

    unit_reservation_checker u_unit_reservation_checker (
        .clk(clk), .rst_n(rst_n), .adv(adv), .req_cls(req_cls),
        .grant(grant), .pipe_sel(pipe_sel), .port_sel(port_sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // reference: bookings derived from the class descriptions
    task automatic model_issue(input logic [2:0] c, output bit g, output bit ps, output bit qs);
        logic [8:0][5:0] nd;
        int wb;
        bit pp, qq, ok;
        nd = '0; pp = 0; wb = 1; ok = 1;
        case (c)
            3'd1: begin pp = mt[0][0]; nd[0][pp ? 1 : 0] = 1; wb = 1; end
            3'd2: begin pp = 1; nd[0][1] = 1; wb = 3; end
            3'd3: begin pp = 1; nd[0][1] = 1; for (int r = 1; r < 9; r++) nd[r][3] = 1; wb = 8; end
            3'd4: begin nd[0][2] = 1; wb = 2; end
            default: ok = 0;
        endcase
        qq = mt[wb][4];
        if (ok) nd[wb][qq ? 5 : 4] = 1;
        g = ok && ((mt & nd) == '0);
        if (g) mt = mt | nd;
        ps = g && pp;
        qs = g && qq;
    endtask

    task automatic step(input logic [2:0] c0, input logic [2:0] c1, input logic [2:0] c2, input bit a);
        logic [2:0] cs [3];
        bit g, ps, qs;
        cs[0] = c0; cs[1] = c1; cs[2] = c2;
        @(negedge clk);
        req_cls = {c2, c1, c0};
        adv = a;
        #2;
        for (int s = 0; s < NS; s++) begin
            model_issue(cs[s], g, ps, qs);
            chk(grant[s] == g, {tag_of(cs[s]), " R7 grant"}, grant[s], g);
            chk(pipe_sel[s] == ps, {tag_of(cs[s]), " pipe"}, pipe_sel[s], ps);
            chk(port_sel[s] == qs, {tag_of(cs[s]), " port"}, port_sel[s], qs);
        end
        if (a) mt = mt >> 6;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_cls = '0;
        adv = 1'b0;
        mt = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0013));
        mt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty table after reset, one of each kind granted
        #1;
        chk(grant == '0, "R1 idle grants", grant, 0);
        step(3'd3, 3'd1, 3'd4, 1'b1);
        chk(1'b1, "R1", 0, 0);
        do_reset();
        step(3'd2, 3'd0, 3'd0, 1'b0);
        chk(grant == 3'b001, "R1 mul after reset", grant, 1);

        // R7: three integer starts in one cycle, third sees the first two
        do_reset();
        step(3'd1, 3'd1, 3'd1, 1'b0);
        chk(grant == 3'b011, "R7 slot order", grant, 3);
        chk(pipe_sel == 3'b010, "R2 pipe fallback", pipe_sel, 2);
        chk(port_sel == 3'b010, "R2 port fallback", port_sel, 2);

        // R8: no advance keeps bookings, second fp start refused
        do_reset();
        step(3'd4, 3'd0, 3'd0, 1'b0);
        step(3'd4, 3'd0, 3'd0, 1'b0);
        chk(grant == 3'b000, "R8 hold without advance", grant, 0);
        step(3'd4, 3'd0, 3'd0, 1'b1);
        chk(grant == 3'b000, "R8 still held", grant, 0);
        step(3'd4, 3'd0, 3'd0, 1'b1);
        chk(grant == 3'b001, "R8 freed after advance", grant, 1);

        // R4: divider busy for eight advances
        do_reset();
        step(3'd3, 3'd0, 3'd0, 1'b1);
        for (int k = 1; k < 8; k++) begin
            step(3'd3, 3'd0, 3'd0, 1'b1);
            chk(grant[0] == 1'b0, "R4 divide blocked", grant[0], 0);
        end
        step(3'd3, 3'd0, 3'd0, 1'b1);
        chk(grant[0] == 1'b1, "R4 divide after gap", grant[0], 1);

        // R3/R5/R6: write-back port contention
        do_reset();
        step(3'd2, 3'd0, 3'd0, 1'b1);
        step(3'd0, 3'd4, 3'd0, 1'b1);
        step(3'd1, 3'd0, 3'd0, 1'b0);
        chk(grant[0] == 1'b0, "R6 ports full", grant[0], 0);
        step(3'd7, 3'd5, 3'd6, 1'b1);
        chk(grant == 3'b000, "R6 unused codes", grant, 0);

        // random mix
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            step(3'($urandom % 6), 3'($urandom % 6), 3'($urandom % 6), ($urandom % 4) != 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule